// File: doc/BRIEF.md
# Addressed Serial Receiver for a Shared Line

This block receives asynchronous serial frames on a line that several nodes share. Each frame carries a flag bit after the byte. When the flag is 1, the frame is an address and names one listener. When the flag is 0, the frame carries payload for whichever listener was last named. The receiver sees every frame on the line. It keeps only the frames meant for it, so traffic for other nodes never raises its receive-full flag or its interrupt.

The line is sampled on a 16x oversampling enable. A falling edge starts a frame, and the start bit is checked again at its midpoint. Each later bit is taken once at the centre of its bit period. A completed frame goes to an address filter. That filter holds the selected state, the receive-data register and the status flags, and it raises single-cycle interrupt pulses. Software clears the receive-full flag after reading the byte. It uses a second clear for the error flags.

Top module: `mpr_rx`

## Requirements
- R1: A frame is one start bit at 0, eight data bits with bit 0 sent first, one address-flag bit, and one stop bit at 1. The line idles at 1. Each bit lasts OVS os_tick pulses (OVS = 16). When a frame is stored, rx_data equals the byte that was sent.
- R2: After reset the node is deselected. While deselected, a frame with the address flag at 0 leaves rx_data, rx_full and rx_irq unchanged.
- R3: A frame with the address flag at 1 whose byte equals local_id sets selected. It also stores that byte in rx_data and sets rx_full.
- R4: A frame with the address flag at 1 whose byte differs from local_id clears selected, even if the node was selected. It does not touch rx_full or rx_data.
- R5: While selected, a data frame (address flag 0) is stored and sets rx_full. rx_irq pulses for exactly one cycle, in the cycle rx_full rises.
- R6: A one-cycle pulse on flag_clr clears rx_full.
- R7: A stop bit sampled as 0 sets frm_err and pulses err_irq for one cycle. The frame is discarded: no data is stored and selected does not change.
- R8: If a frame is accepted while rx_full is still 1, overrun is set and rx_data keeps the byte it already holds.
- R9: A one-cycle pulse on err_clr clears frm_err and overrun.
- R10: A low pulse on the line shorter than half a bit period is rejected and produces no frame.
- R11: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OVS pulses per bit |
| rx_line | input | 1 | Asynchronous serial line, idles high |
| local_id | input | 8 | Address of this node |
| flag_clr | input | 1 | Clears rx_full |
| err_clr | input | 1 | Clears frm_err and overrun |
| rx_data | output | 8 | Last stored byte |
| rx_full | output | 1 | Receive-data-full flag |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| frm_err | output | 1 | Framing-error flag |
| err_irq | output | 1 | One-cycle error interrupt pulse |
| overrun | output | 1 | A byte arrived while rx_full was set |
| selected | output | 1 | Node is currently addressed |

## Verification
The assertions assume three things about the inputs. The line holds each bit for whole periods of OVS oversampling ticks. Clears arrive as short pulses. No clear lands in the same cycle that a completed frame updates the flags, because the set would then take priority and the post-clear properties would not describe the result. The bench keeps os_tick high and drives every bit for exactly sixteen cycles. It issues clear pulses only in the idle gap between frames, well after the stop bit has been sampled.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_FLAG,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              addr_flag;
    logic              stop_ok;
  } frame_t;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/mpr_deser.sv
module mpr_deser
  import mpr_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   os_tick,
  input  logic   rx_s,
  output logic   frm_v,
  output frame_t frm
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  rx_state_t         state;
  logic [CW-1:0]     tick_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              flag_q;
  logic              prev_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tick_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      flag_q   <= 1'b0;
      prev_hi  <= 1'b1;
      frm_v    <= 1'b0;
      frm      <= '0;
    end else begin
      frm_v <= 1'b0;
      if (os_tick) begin
        prev_hi <= rx_s;
        unique case (state)
          ST_IDLE: begin
            // falling edge: previous sample high, current low
            if (prev_hi && !rx_s) begin
              state    <= ST_START;
              tick_cnt <= '0;
            end
          end
          ST_START: begin
            if (tick_cnt == HALF_M1) begin
              tick_cnt <= '0;
              bit_cnt  <= '0;
              state    <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              tick_cnt <= tick_cnt + CW'(1);
            end
          end
          ST_DATA: begin
            if (tick_cnt == FULL_M1) begin
              tick_cnt <= '0;
              shreg    <= {rx_s, shreg[BYTE_W-1:1]};
              if (bit_cnt == LAST_BIT) state <= ST_FLAG;
              else bit_cnt <= bit_cnt + BW'(1);
            end else begin
              tick_cnt <= tick_cnt + CW'(1);
            end
          end
          ST_FLAG: begin
            if (tick_cnt == FULL_M1) begin
              tick_cnt <= '0;
              flag_q   <= rx_s;
              state    <= ST_STOP;
            end else begin
              tick_cnt <= tick_cnt + CW'(1);
            end
          end
          ST_STOP: begin
            if (tick_cnt == FULL_M1) begin
              tick_cnt <= '0;
              frm_v    <= 1'b1;
              frm      <= '{data: shreg, addr_flag: flag_q, stop_ok: rx_s};
              state    <= ST_IDLE;
            end else begin
              tick_cnt <= tick_cnt + CW'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpr_filter.sv
module mpr_filter
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_v,
  input  frame_t            frm,
  input  logic [BYTE_W-1:0] local_id,
  input  logic              flag_clr,
  input  logic              err_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              frm_err,
  output logic              err_irq,
  output logic              overrun,
  output logic              selected
);
  logic good, id_hit, accept;

  always_comb begin
    good   = frm_v && frm.stop_ok;
    id_hit = (frm.data == local_id);
    accept = good && (frm.addr_flag ? id_hit : selected);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_full  <= 1'b0;
      rx_irq   <= 1'b0;
      frm_err  <= 1'b0;
      err_irq  <= 1'b0;
      overrun  <= 1'b0;
      selected <= 1'b0;
    end else begin
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
      if (flag_clr) rx_full <= 1'b0;
      if (err_clr) begin
        frm_err <= 1'b0;
        overrun <= 1'b0;
      end
      if (frm_v && !frm.stop_ok) begin
        frm_err <= 1'b1;
        err_irq <= 1'b1;
      end
      if (good && frm.addr_flag) selected <= id_hit;
      if (accept) begin
        if (rx_full) begin
          overrun <= 1'b1;
        end else begin
          rx_data <= frm.data;
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx
  import mpr_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic [BYTE_W-1:0] local_id,
  input  logic              flag_clr,
  input  logic              err_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              frm_err,
  output logic              err_irq,
  output logic              overrun,
  output logic              selected
);
  logic   rx_s;
  logic   frm_v;
  frame_t frm;

  mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(rx_s)
  );

  mpr_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_s(rx_s),
    .frm_v(frm_v), .frm(frm)
  );

  mpr_filter u_filter (
    .clk(clk), .rst(rst), .frm_v(frm_v), .frm(frm),
    .local_id(local_id), .flag_clr(flag_clr), .err_clr(err_clr),
    .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
    .frm_err(frm_err), .err_irq(err_irq), .overrun(overrun),
    .selected(selected)
  );
endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk
  import mpr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              flag_clr,
  input logic              err_clr,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_irq,
  input logic              frm_err,
  input logic              err_irq,
  input logic              overrun,
  input logic              selected
);
  // R5
  rx_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (rx_full && !$past(rx_full)));

  // R5
  rx_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R8
  held_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_full && $past(rx_full)) |-> $stable(rx_data));

  // R2
  deselected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!selected && !$past(selected)) |-> ($stable(rx_data) && !rx_irq));

  // R7
  err_irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> frm_err);

  // R7
  err_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_irq |=> !err_irq);

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (!rx_full || rx_irq));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> (!frm_err || err_irq));

  // R11
  always_ff @(posedge clk) begin
    if ($past(rst)) begin
      reset_state_chk: assert (!rx_full && !rx_irq && !frm_err && !err_irq
                               && !overrun && !selected && rx_data == '0);
    end
  end
endmodule

bind mpr_rx mpr_rx_chk u_chk (
  .clk(clk), .rst(rst), .flag_clr(flag_clr), .err_clr(err_clr),
  .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
  .frm_err(frm_err), .err_irq(err_irq), .overrun(overrun),
  .selected(selected)
);

// File: tb/tb_mpr_rx.sv
module tb_mpr_rx;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int OVS = 16;
  localparam logic [7:0] ID_A = 8'h5A;
  localparam logic [7:0] ID_B = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b1;
  logic rx_line = 1'b1;
  logic flag_clr = 1'b0;
  logic err_clr = 1'b0;

  logic [7:0] o_data [2];
  logic o_full [2], o_irq [2], o_ferr [2], o_eirq [2], o_ovr [2], o_sel [2];
  logic [7:0] ids [2];

  // expected state per node
  logic [7:0] m_data [2];
  logic m_full [2], m_ferr [2], m_ovr [2], m_sel [2];
  int   m_irq [2], m_eirq [2];
  int   a_irq [2], a_eirq [2];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  initial begin
    ids[0] = ID_A;
    ids[1] = ID_B;
  end

  mpr_rx dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .local_id(ID_A), .flag_clr(flag_clr), .err_clr(err_clr),
    .rx_data(o_data[0]), .rx_full(o_full[0]), .rx_irq(o_irq[0]),
    .frm_err(o_ferr[0]), .err_irq(o_eirq[0]), .overrun(o_ovr[0]),
    .selected(o_sel[0])
  );

  mpr_rx dut2 (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .local_id(ID_B), .flag_clr(flag_clr), .err_clr(err_clr),
    .rx_data(o_data[1]), .rx_full(o_full[1]), .rx_irq(o_irq[1]),
    .frm_err(o_ferr[1]), .err_irq(o_eirq[1]), .overrun(o_ovr[1]),
    .selected(o_sel[1])
  );

  always @(posedge clk) begin
    if (!rst) begin
      for (int n = 0; n < 2; n++) begin
        if (o_irq[n])  a_irq[n]++;
        if (o_eirq[n]) a_eirq[n]++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_node(input int n, input string req);
    chk(req, $sformatf("node%0d rx_full", n), int'(o_full[n]), int'(m_full[n]));
    chk({req, " R1"}, $sformatf("node%0d rx_data", n), int'(o_data[n]), int'(m_data[n]));
    chk(req, $sformatf("node%0d selected", n), int'(o_sel[n]), int'(m_sel[n]));
    chk(req, $sformatf("node%0d frm_err", n), int'(o_ferr[n]), int'(m_ferr[n]));
    chk(req, $sformatf("node%0d overrun", n), int'(o_ovr[n]), int'(m_ovr[n]));
    chk(req, $sformatf("node%0d rx_irq count", n), a_irq[n], m_irq[n]);
    chk(req, $sformatf("node%0d err_irq count", n), a_eirq[n], m_eirq[n]);
  endtask

  function automatic string tag_for(input int n, input logic [7:0] b, input bit fl, input bit stp);
    if (!stp) return "R7";
    if (fl) return (b == ids[n]) ? "R3" : "R4";
    if (!m_sel[n]) return "R2";
    return m_full[n] ? "R8" : "R5";
  endfunction

  task automatic model_frame(input int n, input logic [7:0] b, input bit fl, input bit stp);
    bit acc;
    if (!stp) begin
      m_ferr[n] = 1'b1;
      m_eirq[n]++;
    end else begin
      acc = fl ? (b == ids[n]) : m_sel[n];
      if (fl) m_sel[n] = (b == ids[n]);
      if (acc) begin
        if (m_full[n]) m_ovr[n] = 1'b1;
        else begin
          m_data[n] = b;
          m_full[n] = 1'b1;
          m_irq[n]++;
        end
      end
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (OVS) @(negedge clk);
  endtask

  // one frame, two idle bits, then model update and check of both nodes
  task automatic send_frame(input logic [7:0] b, input bit fl, input bit stp);
    string tg [2];
    for (int n = 0; n < 2; n++) tg[n] = tag_for(n, b, fl, stp);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(fl);
    drive_bit(stp);
    drive_bit(1'b1);
    drive_bit(1'b1);
    for (int n = 0; n < 2; n++) begin
      model_frame(n, b, fl, stp);
      check_node(n, tg[n]);
    end
  endtask

  task automatic pulse_flag_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      m_full[n] = 1'b0;
      chk("R6", $sformatf("node%0d rx_full after clear", n), int'(o_full[n]), 0);
    end
  endtask

  task automatic pulse_err_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      m_ferr[n] = 1'b0;
      m_ovr[n]  = 1'b0;
      chk("R9", $sformatf("node%0d frm_err after clear", n), int'(o_ferr[n]), 0);
      chk("R9", $sformatf("node%0d overrun after clear", n), int'(o_ovr[n]), 0);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    bit fl, stp;
    void'($urandom(32'd4242));
    for (int n = 0; n < 2; n++) begin
      m_data[n] = '0; m_full[n] = 0; m_ferr[n] = 0; m_ovr[n] = 0; m_sel[n] = 0;
      m_irq[n] = 0; m_eirq[n] = 0; a_irq[n] = 0; a_eirq[n] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 2; n++) check_node(n, "R11");

    // directed corner cases
    send_frame(8'h33, 1'b0, 1'b1);   // R2: nobody selected
    send_frame(ID_A, 1'b1, 1'b1);    // R3 for node 0, R4 for node 1
    pulse_flag_clr();
    send_frame(8'hA5, 1'b0, 1'b1);   // R5 / R1
    send_frame(8'h0F, 1'b0, 1'b1);   // R8: held byte kept
    pulse_flag_clr();
    send_frame(8'h81, 1'b0, 1'b1);   // R5
    send_frame(8'hFF, 1'b0, 1'b0);   // R7: bad stop bit
    pulse_err_clr();
    pulse_flag_clr();
    send_frame(ID_B, 1'b1, 1'b1);    // R4 deselects node 0, R3 selects node 1
    send_frame(8'h77, 1'b0, 1'b1);   // node 1 only
    pulse_flag_clr();
    // R10: short low glitch
    rx_line = 1'b0;
    repeat (OVS / 4) @(negedge clk);
    rx_line = 1'b1;
    repeat (4 * OVS) @(negedge clk);
    for (int n = 0; n < 2; n++) check_node(n, "R10");

    // random traffic
    for (int i = 0; i < 300; i++) begin
      fl = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: b = ID_A;
        1: b = ID_B;
        default: b = 8'($urandom);
      endcase
      stp = ($urandom % 25) != 0;
      if (($urandom % 2) == 0) pulse_flag_clr();
      if (($urandom % 8) == 0) pulse_err_clr();
      send_frame(b, fl, stp);
    end
    finish_run();
  end
endmodule